// File: doc/BRIEF.md
# Level-Adaptive Writeback Routing Table

This block sits in the shared second-level cache controller of a cluster of cores. It keeps one slot for each core of the cluster. Each slot records which software thread currently runs on that core. Software issues coherence operations that name a partner thread: either a producer writeback that names the consumer thread, or a consumer self-invalidate that names the producer thread. The block decides how far each operation must travel. If the partner thread lives inside the cluster, the shared second level is the closest common point, so the operation stops there. Otherwise it must also reach the third level.

The mapping is kept up to date through a write port and a clear port. Both are indexed by core number, so moving a thread onto a core replaces whatever that core held before. A lookup takes a request carrying the partner ID, the operation kind and a whole-path flag. The whole-path flag forces the operation to the third level no matter what the table holds. The lookup compares the partner ID against every valid slot at once and answers one cycle later with a two-bit route.

Top module: `lvl_route_table`

## Requirements
- R1: After reset every slot is empty, so any lookup misses, and `rsp_valid` is low until a request is made.
- R2: A mapping write with `map_we` high stores `map_tid` in slot `map_core` and marks it valid; later lookups of that ID hit.
- R3: A lookup whose partner ID matches a valid slot and whose `req_full` is low returns `rsp_route` = 2'b01 (bit 0 = second level, bit 1 = third level), meaning second level only.
- R4: A lookup whose partner ID matches no valid slot returns `rsp_route` = 2'b11, meaning second and third level.
- R5: Writebacks (`req_kind` = 0) and invalidates (`req_kind` = 1) follow the same routing rule, and `rsp_kind` echoes the request's kind.
- R6: With `req_full` high the route is 2'b11 whatever the table contents.
- R7: Writing a new ID into an occupied slot replaces the old ID, so the old ID misses afterwards unless another slot holds it.
- R8: `map_clr` empties slot `map_core`; when `map_clr` and `map_we` are both high in one cycle, the clear wins and the slot ends up empty.
- R9: A lookup sees the table as it stood before any mapping update made in the same cycle.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the route is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Write thread ID into a core slot |
| map_clr | input | 1 | Empty a core slot (wins over `map_we`) |
| map_core | input | CW | Core slot index for write or clear |
| map_tid | input | TID_W | Thread ID to store |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 1 | 0 = producer writeback, 1 = consumer invalidate |
| req_full | input | 1 | Force the whole path to the third level |
| req_tid | input | TID_W | Partner thread ID to look up |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_kind | output | 1 | Echo of the request kind |
| rsp_route | output | 2 | Bit 0 second level, bit 1 third level |

## Verification
Each lookup is answered in the cycle after the cycle in which it is presented. Table updates take effect on the same clock edge, so they are visible only to requests made in the following cycle. The bench drives every request and update on the falling edge. It reads the response on the next falling edge, which is exactly one rising edge later. That edge is where both the response register and the table have moved. For the same-cycle case (R9), the bench predicts the answer from its model as it stood before the update.

// File: rtl/lvl_route_table.sv
module lvl_route_table #(
  parameter int CORES = 8,
  parameter int TID_W = 4,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_we,
  input  logic             map_clr,
  input  logic [CW-1:0]    map_core,
  input  logic [TID_W-1:0] map_tid,
  input  logic             req_valid,
  input  logic             req_kind,
  input  logic             req_full,
  input  logic [TID_W-1:0] req_tid,
  output logic             rsp_valid,
  output logic             rsp_kind,
  output logic [1:0]       rsp_route
);

  localparam logic [1:0] ROUTE_NEAR = 2'b01;
  localparam logic [1:0] ROUTE_FAR  = 2'b11;

  logic [CORES-1:0] slot_vld;
  logic [TID_W-1:0] slot_tid [CORES];
  logic [CORES-1:0] match;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rst_n)
      slot_vld <= '0;
    else if (map_clr)
      slot_vld[map_core] <= 1'b0;
    else if (map_we)
      slot_vld[map_core] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (map_we && !map_clr)
      slot_tid[map_core] <= map_tid;
  end

  for (genvar i = 0; i < CORES; i++) begin : g_cmp
    assign match[i] = slot_vld[i] && (slot_tid[i] == req_tid);
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= 1'b0;
      rsp_route <= ROUTE_FAR;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind  <= req_kind;
        rsp_route <= (req_full || !hit) ? ROUTE_FAR : ROUTE_NEAR;
      end
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_route_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_route == ROUTE_NEAR || rsp_route == ROUTE_FAR));
  assert_full_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_full) |=> rsp_route == ROUTE_FAR);
  assert_kind_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_kind == $past(req_kind));
  assert_miss_far_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && slot_vld == '0) |=> rsp_route == ROUTE_FAR);
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_clr && map_we) |=> !slot_vld[$past(map_core)]);

endmodule

// File: tb/sim_lvl_route_table.sv
module sim_lvl_route_table;
  localparam int CLK_PERIOD = 10;
  localparam int CORES = 8;
  localparam int TID_W = 4;
  localparam int CW = 3;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             map_we = 1'b0, map_clr = 1'b0;
  logic [CW-1:0]    map_core = '0;
  logic [TID_W-1:0] map_tid = '0;
  logic             req_valid = 1'b0, req_kind = 1'b0, req_full = 1'b0;
  logic [TID_W-1:0] req_tid = '0;
  logic             rsp_valid, rsp_kind;
  logic [1:0]       rsp_route;

  lvl_route_table #(.CORES(CORES), .TID_W(TID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_clr(map_clr),
    .map_core(map_core), .map_tid(map_tid), .req_valid(req_valid),
    .req_kind(req_kind), .req_full(req_full), .req_tid(req_tid),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_route(rsp_route));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  bit             m_vld [CORES];
  logic [TID_W-1:0] m_tid [CORES];

  function automatic logic [1:0] expect_route(input logic [TID_W-1:0] t, input bit full);
    bit h = 0;
    for (int i = 0; i < CORES; i++) if (m_vld[i] && m_tid[i] == t) h = 1;
    return (full || !h) ? 2'b11 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic map_write(input int core, input logic [TID_W-1:0] t);
    @(negedge clk);
    map_we = 1; map_core = CW'(core); map_tid = t;
    @(negedge clk);
    map_we = 0;
    m_vld[core] = 1; m_tid[core] = t;
  endtask

  task automatic map_clear(input int core);
    @(negedge clk);
    map_clr = 1; map_core = CW'(core);
    @(negedge clk);
    map_clr = 0;
    m_vld[core] = 0;
  endtask

  task automatic lookup(input string req, input bit kind, input logic [TID_W-1:0] t, input bit full);
    logic [1:0] exp;
    exp = expect_route(t, full);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_tid = t; req_full = full;
    @(negedge clk);
    req_valid = 0;
    check({req, " R10 valid"}, {1'b0, rsp_valid}, 2'b01);
    check({req, " R5 kind"}, {1'b0, rsp_kind}, {1'b0, kind});
    check(req, rsp_route, exp);
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < (1 << TID_W); t++)
      for (int k = 0; k < 2; k++)
        for (int f = 0; f < 2; f++)
          lookup(f ? "R6" : req, k[0], TID_W'(t), f[0]);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < CORES; i++) begin m_vld[i] = 0; m_tid[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {1'b0, rsp_valid}, 2'b00);
    sweep("R1");                              // empty table: all miss
    for (int c = 0; c < CORES; c++) map_write(c, TID_W'(2 * c));
    sweep("R2 R3 R4");                        // even IDs hit, odd miss
    map_write(3, 4'd1);
    sweep("R7");                              // ID 6 gone, ID 1 present
    map_clear(5);
    sweep("R8");                              // ID 10 gone
    @(negedge clk);
    map_we = 1; map_clr = 1; map_core = 3'd0; map_tid = 4'd9;
    @(negedge clk);
    map_we = 0; map_clr = 0;
    m_vld[0] = 0;
    lookup("R8 clear wins", 0, 4'd9, 0);
    lookup("R8 clear wins", 1, 4'd0, 0);
    @(negedge clk);                           // same-cycle update and lookup
    map_we = 1; map_core = 3'd2; map_tid = 4'd11;
    req_valid = 1; req_kind = 0; req_tid = 4'd11; req_full = 0;
    @(negedge clk);
    map_we = 0; req_valid = 0;
    check("R9 old table", rsp_route, 2'b11);
    m_vld[2] = 1; m_tid[2] = 4'd11;
    lookup("R9 new table", 1, 4'd11, 0);
    @(negedge clk);
    check("R10 drop", {1'b0, rsp_valid}, 2'b00);
    summary();
  end
endmodule